// File: doc/BRIEF.md
# Random Word Source Command/Status Controller

This block sits behind a small register window and wraps a pseudo-random bit source. Software drives a fixed sequence of 32-bit command words into a write-only control register. Each phase the block reaches is shown as an 8-bit code in a read-only status register. The phases are: acknowledged reset, released, enabled, zeroized with a startup health test, and word generation. Software reads finished random words from a data register. That register sits at the same offset as the control register, but it is reached through the read path.

Once startup passes and software acknowledges it, the block gathers one full 32-bit word from the source and raises the "word available" code. It then waits. Software reads the word, writes a read acknowledge, and writes enable to ask for the next word. The startup health test watches a fixed number of source samples and fails when a run of identical bits is too long. A test input forces the failing path. All waiting intervals are counted in clock cycles and set by parameters.

Top module: `rng_cmd_ctrl`

## Requirements
- R1: Writes take effect only at offset 0x0. A read at offset 0x4 returns the status code in bits 7:0 with bits 31:8 zero. A read at offset 0x0 returns the data register. A command written at any offset other than 0x0 has no effect.
- R2: Out of power-on reset the status is 0x00. A reset command (0x00000001) makes the status 0x00 for RESET_DLY cycles and then 0xAC.
- R3: Startup is accepted only in this order: release (0x00000002) while the status is 0xAC, then enable (0x80000000), then zeroize (0x80000004). The same codes written out of order are ignored.
- R4: Zeroize reloads the source with its fixed seed and clears the word. It then runs the health test for TEST_SAMPLES cycles with status 0x00, and ends with 0x57 (pass) or 0xFA (fail). The source is always reseeded, so the first word after each startup is the same.
- R5: The test fails when more than RUN_LIMIT equal samples occur in a row. Holding test_force_fail high makes every sample 0, which forces the fail result. Once the status is 0xFA, only a reset command changes it.
- R6: Acknowledge zeroize (0x80000008) written while the status is 0x57 starts generation. Generation takes 32 cycles of status 0x00, after which the status reads 0xED.
- R7: A read at offset 0x0 returns 0 whenever the status is not 0xED. It returns a complete, non-zero word while the status is 0xED.
- R8: Read acknowledge (0x8000000F) written while the status is 0xED sets the status to 0x00 and clears the data read. A following enable starts the next word. Successive words differ.
- R9: A write of any code not listed here, or of a listed code in a state that does not accept it, leaves both the status and the data unchanged.
- R10: A reset command is honoured from every state, including word-ready and test-failed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write byte offset |
| wr_data | input | 32 | Write data (command code) |
| rd_addr | input | ADDR_W | Read byte offset |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| test_force_fail | input | 1 | Forces health-test samples to 0 |

## Verification
The assertions check the per-cycle rules on every clock. A reset command lands in the reset wait state one cycle later. The 0xAC code is reached only from that wait. The word-ready state is entered only from generation and always holds a non-zero word. A failed test stays failed until a reset. A run longer than the limit always sets the failure flag. Some behaviour shows only in the bench's scenarios: the exact phase lengths, the ordering rules, codes that are ignored, offsets that are ignored, the match of the first word after each reseed, and the difference between successive words. The bench tracks all of these with a cycle-by-cycle model.

// File: rtl/rng_cmd_pkg.sv
package rng_cmd_pkg;

  localparam logic [31:0] CODE_RESET    = 32'h0000_0001;
  localparam logic [31:0] CODE_RELEASE  = 32'h0000_0002;
  localparam logic [31:0] CODE_ENABLE   = 32'h8000_0000;
  localparam logic [31:0] CODE_ZEROIZE  = 32'h8000_0004;
  localparam logic [31:0] CODE_ACK_ZERO = 32'h8000_0008;
  localparam logic [31:0] CODE_READ_ACK = 32'h8000_000F;

  localparam logic [7:0] STAT_BUSY  = 8'h00;
  localparam logic [7:0] STAT_RACK  = 8'hAC;
  localparam logic [7:0] STAT_PASS  = 8'h57;
  localparam logic [7:0] STAT_FAIL  = 8'hFA;
  localparam logic [7:0] STAT_READY = 8'hED;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_RESET,
    CMD_RELEASE,
    CMD_ENABLE,
    CMD_ZEROIZE,
    CMD_ACK_ZERO,
    CMD_READ_ACK
  } cmd_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RWAIT,
    ST_RACK,
    ST_RELEASED,
    ST_ENABLED,
    ST_SELFTEST,
    ST_PASS,
    ST_FAIL,
    ST_GEN,
    ST_READY,
    ST_ACKED
  } state_e;

endpackage

// File: rtl/rng_cmd_decode.sv
module rng_cmd_decode
  import rng_cmd_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int CTRL_OFF = 0
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  output cmd_e              cmd
);

  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFF);

  always_comb begin
    cmd = CMD_NONE;
    if (wr_en && (wr_addr == CTRL_A)) begin
      unique case (wr_data)
        CODE_RESET:    cmd = CMD_RESET;
        CODE_RELEASE:  cmd = CMD_RELEASE;
        CODE_ENABLE:   cmd = CMD_ENABLE;
        CODE_ZEROIZE:  cmd = CMD_ZEROIZE;
        CODE_ACK_ZERO: cmd = CMD_ACK_ZERO;
        CODE_READ_ACK: cmd = CMD_READ_ACK;
        default:       cmd = CMD_NONE;
      endcase
    end
  end

endmodule

// File: rtl/rng_entropy_stub.sv
module rng_entropy_stub #(
  parameter int          W    = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic reseed,
  input  logic advance,
  output logic bit_o
);

  logic [W-1:0] q_q, q_d;
  logic         en;

  assign en = reseed | advance;

  always_comb begin
    q_d = q_q;
    if (reseed)       q_d = SEED;
    else if (advance) q_d = {q_q[W-2:0], ^(q_q & TAPS)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_q <= SEED;
    else if (en) q_q <= q_d;
  end

  assign bit_o = q_q[W-1];

  // R4: the source state never collapses to the all-zero lock-up value
  a_r4_state_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    q_q != '0);

endmodule

// File: rtl/rng_health_test.sv
module rng_health_test #(
  parameter int SAMPLES   = 64,
  parameter int RUN_LIMIT = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic sample_en,
  input  logic sample,
  output logic last_o,
  output logic fail_o
);

  localparam int CNT_W = $clog2(SAMPLES + 1);
  localparam int RUN_W = $clog2(SAMPLES + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [RUN_W-1:0] run_q, run_d;
  logic             prev_q;
  logic             fail_q, fail_d;
  logic             en;

  assign en = clear | sample_en;

  always_comb begin
    cnt_d  = cnt_q;
    run_d  = run_q;
    fail_d = fail_q;
    if (clear) begin
      cnt_d  = '0;
      run_d  = '0;
      fail_d = 1'b0;
    end else if (sample_en) begin
      cnt_d = cnt_q + 1'b1;
      if ((cnt_q != '0) && (sample == prev_q)) run_d = run_q + 1'b1;
      else                                     run_d = RUN_W'(1);
      if (run_d > RUN_W'(RUN_LIMIT)) fail_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      run_q  <= '0;
      prev_q <= 1'b0;
      fail_q <= 1'b0;
    end else if (en) begin
      cnt_q  <= cnt_d;
      run_q  <= run_d;
      prev_q <= sample;
      fail_q <= fail_d;
    end
  end

  assign last_o = sample_en && !clear && (cnt_q == CNT_W'(SAMPLES - 1));
  assign fail_o = fail_d;

  // R5: a run past the limit always leaves the failure flag set
  a_r5_run_flags_fail: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q > RUN_W'(RUN_LIMIT)) |-> fail_q);

endmodule

// File: rtl/rng_word_collect.sv
module rng_word_collect #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              shift_en,
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_o,
  output logic              full_o
);

  localparam int CNT_W = $clog2(WORD_W);

  logic [WORD_W-1:0] word_q, word_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              en;

  assign en     = clear | shift_en;
  assign full_o = shift_en && !clear && (cnt_q == CNT_W'(WORD_W - 1));

  always_comb begin
    word_d = word_q;
    cnt_d  = cnt_q;
    if (clear) begin
      word_d = '0;
      cnt_d  = '0;
    end else if (shift_en) begin
      word_d = {word_q[WORD_W-2:0], bit_i};
      cnt_d  = full_o ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      cnt_q  <= '0;
    end else if (en) begin
      word_q <= word_d;
      cnt_q  <= cnt_d;
    end
  end

  assign word_o = word_q;

  // R6: a clear always leaves an empty word behind
  a_r6_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (word_q == '0));

endmodule

// File: rtl/rng_cmd_ctrl.sv
module rng_cmd_ctrl
  import rng_cmd_pkg::*;
#(
  parameter int ADDR_W       = 4,
  parameter int CTRL_OFF     = 0,
  parameter int STAT_OFF     = 4,
  parameter int RESET_DLY    = 16,
  parameter int TEST_SAMPLES = 64,
  parameter int RUN_LIMIT    = 20,
  parameter int SRC_W        = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  input  logic              test_force_fail
);

  localparam int                DLY_W  = $clog2(RESET_DLY + 1);
  localparam int                WORD_W = 32;
  localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(CTRL_OFF);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFF);

  cmd_e              cmd;
  state_e            st_q, st_d;
  logic [DLY_W-1:0]  dly_q, dly_d;
  logic              src_bit, src_reseed, src_adv;
  logic              hl_clear, hl_last, hl_fail, hl_sample;
  logic              wc_clear, wc_full;
  logic [WORD_W-1:0] word;
  logic [7:0]        status;

  rng_cmd_decode #(.ADDR_W(ADDR_W), .CTRL_OFF(CTRL_OFF)) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .cmd(cmd));

  assign src_reseed = (cmd == CMD_RESET) || (st_q == ST_ENABLED && cmd == CMD_ZEROIZE);
  assign src_adv    = (st_q == ST_SELFTEST) || (st_q == ST_GEN);

  rng_entropy_stub #(.W(SRC_W)) u_src (
    .clk(clk), .rst_n(rst_n), .reseed(src_reseed), .advance(src_adv), .bit_o(src_bit));

  assign hl_clear  = src_reseed;
  assign hl_sample = test_force_fail ? 1'b0 : src_bit;

  rng_health_test #(.SAMPLES(TEST_SAMPLES), .RUN_LIMIT(RUN_LIMIT)) u_hlth (
    .clk(clk), .rst_n(rst_n), .clear(hl_clear), .sample_en(st_q == ST_SELFTEST),
    .sample(hl_sample), .last_o(hl_last), .fail_o(hl_fail));

  assign wc_clear = src_reseed
                 || (st_q == ST_PASS  && cmd == CMD_ACK_ZERO)
                 || (st_q == ST_READY && cmd == CMD_READ_ACK)
                 || (st_q == ST_ACKED && cmd == CMD_ENABLE);

  rng_word_collect #(.WORD_W(WORD_W)) u_word (
    .clk(clk), .rst_n(rst_n), .clear(wc_clear), .shift_en(st_q == ST_GEN),
    .bit_i(src_bit), .word_o(word), .full_o(wc_full));

  always_comb begin
    st_d  = st_q;
    dly_d = dly_q;
    if (cmd == CMD_RESET) begin
      st_d  = ST_RWAIT;
      dly_d = '0;
    end else begin
      unique case (st_q)
        ST_RWAIT:
          if (dly_q == DLY_W'(RESET_DLY - 1)) st_d = ST_RACK;
          else                                dly_d = dly_q + 1'b1;
        ST_RACK:     if (cmd == CMD_RELEASE)  st_d = ST_RELEASED;
        ST_RELEASED: if (cmd == CMD_ENABLE)   st_d = ST_ENABLED;
        ST_ENABLED:  if (cmd == CMD_ZEROIZE)  st_d = ST_SELFTEST;
        ST_SELFTEST: if (hl_last)             st_d = hl_fail ? ST_FAIL : ST_PASS;
        ST_PASS:     if (cmd == CMD_ACK_ZERO) st_d = ST_GEN;
        ST_GEN:      if (wc_full)             st_d = ST_READY;
        ST_READY:    if (cmd == CMD_READ_ACK) st_d = ST_ACKED;
        ST_ACKED:    if (cmd == CMD_ENABLE)   st_d = ST_GEN;
        default:     st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      dly_q <= '0;
    end else begin
      st_q  <= st_d;
      dly_q <= dly_d;
    end
  end

  always_comb begin
    unique case (st_q)
      ST_RACK:  status = STAT_RACK;
      ST_PASS:  status = STAT_PASS;
      ST_FAIL:  status = STAT_FAIL;
      ST_READY: status = STAT_READY;
      default:  status = STAT_BUSY;
    endcase
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == STAT_A)                         rd_data = {24'h0, status};
    else if (rd_addr == DATA_A && st_q == ST_READY) rd_data = word;
  end

  // R10: reset command is taken from any state
  a_r10_reset_any: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_RESET) |=> (st_q == ST_RWAIT));

  // R2: reset acknowledge is reached only through the wait phase
  a_r2_ack_via_wait: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q == ST_RACK) |-> ($past(st_q) == ST_RWAIT));

  // R5: a failed startup holds until reset
  a_r5_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FAIL && cmd != CMD_RESET) |=> (st_q == ST_FAIL));

  // R6: word-ready only follows generation
  a_r6_ready_from_gen: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q == ST_READY) |-> ($past(st_q) == ST_GEN));

  // R7: an offered word is never empty
  a_r7_ready_word_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_READY) |-> (word != '0));

endmodule

// File: tb/rng_cmd_ctrl_test.sv
`timescale 1ns/100ps
module rng_cmd_ctrl_test;

  localparam int RD  = 10;
  localparam int TS  = 64;
  localparam int RL  = 20;
  localparam int AW  = 4;

  localparam logic [31:0] C_RST = 32'h0000_0001, C_REL = 32'h0000_0002,
                          C_EN  = 32'h8000_0000, C_ZER = 32'h8000_0004,
                          C_AKZ = 32'h8000_0008, C_RAK = 32'h8000_000F;

  // model phases
  localparam int P_IDLE = 0, P_RW = 1, P_AC = 2, P_REL = 3, P_EN = 4, P_ST = 5,
                 P_PASS = 6, P_FAIL = 7, P_GEN = 8, P_RDY = 9, P_AKD = 10;

  logic          clk, rst_n, wr_en, force_fail;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [31:0]   wr_data, rd_data;

  int total, bad;
  int m_st, m_cnt;
  bit m_bad;
  logic [31:0] s_stat, s_data;

  rng_cmd_ctrl #(.ADDR_W(AW), .RESET_DLY(RD), .TEST_SAMPLES(TS), .RUN_LIMIT(RL)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .test_force_fail(force_fail));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [7:0] m_status(input int st);
    case (st)
      P_AC:    return 8'hAC;
      P_PASS:  return 8'h57;
      P_FAIL:  return 8'hFA;
      P_RDY:   return 8'hED;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = P_IDLE; m_cnt = 0; m_bad = 0;
    end else begin
      logic cmd_hit;
      cmd_hit = wr_en && (wr_addr == 0);
      if (cmd_hit && wr_data == C_RST) begin
        m_st = P_RW; m_cnt = 0;
      end else begin
        case (m_st)
          P_RW: if (m_cnt == RD - 1) m_st = P_AC; else m_cnt++;
          P_AC: if (cmd_hit && wr_data == C_REL) m_st = P_REL;
          P_REL: if (cmd_hit && wr_data == C_EN) m_st = P_EN;
          P_EN: if (cmd_hit && wr_data == C_ZER) begin m_st = P_ST; m_cnt = 0; m_bad = 0; end
          P_ST: begin
            if (force_fail) m_bad = 1;
            if (m_cnt == TS - 1) m_st = m_bad ? P_FAIL : P_PASS; else m_cnt++;
          end
          P_PASS: if (cmd_hit && wr_data == C_AKZ) begin m_st = P_GEN; m_cnt = 0; end
          P_GEN: if (m_cnt == 31) m_st = P_RDY; else m_cnt++;
          P_RDY: if (cmd_hit && wr_data == C_RAK) m_st = P_AKD;
          P_AKD: if (cmd_hit && wr_data == C_EN) begin m_st = P_GEN; m_cnt = 0; end
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      rd_addr = 4'h4; #0.5 s_stat = rd_data;
      rd_addr = 4'h0; #0.5 s_data = rd_data;
      check("R1/R2/R4/R6 status per cycle", s_stat, {24'h0, m_status(m_st)});
      if (m_st != P_RDY) check("R7 data hidden when not ready", s_data, 32'h0);
      else begin
        total++;
        if (s_data == 32'h0) begin bad++; $display("FAIL R7: actual=%h expected=nonzero", s_data); end
      end
    end
  end

  task automatic cmd_at(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = 32'h0;
  endtask

  task automatic cmd(input logic [31:0] d);
    cmd_at(4'h0, d);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
    #1.5;
  endtask

  task automatic startup(input bit ff);
    cmd(C_RST); settle(RD + 1);
    cmd(C_REL); cmd(C_EN);
    force_fail = ff;
    cmd(C_ZER); settle(TS + 2);
  endtask

  logic [31:0] w1, w2, w3;

  initial begin
    total = 0; bad = 0;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0; force_fail = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle(1);
    check("R2 power-on status", s_stat, 32'h0);
    check("R1 status upper bits", s_stat & 32'hFFFF_FF00, 32'h0);

    cmd(32'h1234_5678); settle(1);
    check("R9 unknown code in idle", s_stat, 32'h0);
    cmd_at(4'h4, C_RST); settle(RD + 2);
    check("R1 command at status offset ignored", s_stat, 32'h0);

    cmd(C_RST); settle(RD + 1);
    check("R2 reset acknowledged", s_stat, 32'hAC);
    cmd(C_EN); cmd(C_ZER); settle(1);
    check("R3 enable/zeroize before release ignored", s_stat, 32'hAC);
    cmd(C_REL); settle(1);
    check("R3 release accepted", s_stat, 32'h0);
    cmd(C_ZER); settle(1);
    cmd(C_EN); cmd(C_ZER); settle(TS + 2);
    check("R4 self-test pass", s_stat, 32'h57);

    cmd(C_AKZ); settle(34);
    check("R6 word ready", s_stat, 32'hED);
    w1 = s_data;
    check("R7 word nonzero", {31'h0, w1 != 0}, 32'h1);
    cmd(32'h8000_0001); cmd(C_EN); settle(1);
    check("R9 ignored code keeps ready", s_stat, 32'hED);
    check("R9 ignored code keeps word", s_data, w1);

    cmd(C_RAK); settle(1);
    check("R8 read ack clears status", s_stat, 32'h0);
    check("R8 read ack clears data", s_data, 32'h0);
    cmd(C_EN); settle(34);
    w2 = s_data;
    check("R8 next word ready", s_stat, 32'hED);
    check("R8 successive words differ", {31'h0, w2 != w1}, 32'h1);

    startup(1'b0);
    cmd(C_AKZ); settle(34);
    w3 = s_data;
    check("R4 reseed repeats first word", w3, w1);

    cmd(C_RST); settle(1);
    check("R10 reset from ready", s_stat, 32'h0);
    check("R10 data hidden after reset", s_data, 32'h0);

    startup(1'b1);
    check("R5 forced failure", s_stat, 32'hFA);
    force_fail = 1'b0;
    cmd(C_AKZ); cmd(C_EN); cmd(C_RAK); settle(2);
    check("R5 failure is sticky", s_stat, 32'hFA);
    cmd(C_RST); settle(RD + 1);
    check("R10 reset from failed", s_stat, 32'hAC);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule